// File: doc/BRIEF.md
# Buffered Up/Down Timer with Command and DMA-Acknowledge Interface

This block is a timer/counter of parameterised width. It counts up or down on an external clock enable. Its period register and its single compare register each have a buffer. A buffered value becomes active only on an update event. An update event is either the counter wrapping or a software update command.

Software can also force a restart or a full reset through a command register. Two sticky flags serve as interrupt sources and DMA request lines:
- the wrap flag,
- the compare-match flag.

A DMA master clears a flag as a side effect of touching the registers that belong to it. The CPU clears a flag only by writing one to it.

All registers sit on a small register bus. The bus has an address, write data, write and read strobes, and a tag that marks the access as coming from the DMA master. Read data is combinational from the address.

Register map, by 3-bit address:

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit0 = run, bit1 = lock-update, bit2 = count down |
| 1 | command | write-only, reads 0; bit0 = update, bit1 = restart, bit2 = reset |
| 2 | flags | bit0 = wrap, bit1 = compare |
| 3 | counter | |
| 4 | active period | |
| 5 | period buffer | |
| 6 | active compare | |
| 7 | compare buffer | |

Top module: `tc_cmd_timer`

## Requirements
- R1: Counting up, on a tick where the counter equals the active period, the counter goes to zero and the wrap flag (bit0 of address 2, output `ovf_req`) sets. Otherwise it increments.
- R2: Counting down (control bit2 = 1), on a tick where the counter is zero, the counter loads the active period and the wrap flag sets. Otherwise it decrements.
- R3: A restart command (address 1, bit1) zeroes the counter, clears the down bit in control and drives `cmp_out` low. It keeps the run and lock bits.
- R4: Writing address 5 or 7 stores the value in the buffer and marks the buffer valid. On an update event (wrap, or command bit0), each valid buffer is copied into its active register and its valid mark clears. Writing address 4 or 6 changes the active value at once.
- R5: While control bit1 (lock) is set, update events copy no buffer, whether they come from a wrap or a command. The valid marks are kept for later.
- R6: A reset command (address 1, bit2) returns every register to its power-on value: period all ones, everything else zero, flags clear. It takes effect only while control bit0 (run) is 0 and is ignored otherwise.
- R7: On a tick where the counter equals the active compare value, the compare flag (bit1, output `cmp_req`) sets. On each tick `cmp_out` takes the value (counter < active compare).
- R8: The wrap flag clears on a DMA-tagged write to address 3, 4 or 5. The compare flag clears on a DMA-tagged read or write of address 6 or 7. The same accesses from the CPU leave the flags alone. A flag set and a flag clear in the same cycle leave the flag set.
- R9: A write of one to a bit of the flags register clears that flag. A zero leaves it unchanged.
- R10: When several command bits are written together, reset takes precedence over restart, and restart over update. A reset that is refused while running lets restart act.
- R11: The counter advances only on cycles where `clk_en` is high and control bit0 (run) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Count tick enable |
| bus_addr | input | AW | Register address |
| bus_wdata | input | W | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used for DMA acknowledge) |
| bus_dma | input | 1 | Access comes from the DMA master |
| bus_rdata | output | W | Read data for `bus_addr` |
| ovf_req | output | 1 | Wrap flag / DMA request |
| cmp_req | output | 1 | Compare flag / DMA request |
| cmp_out | output | 1 | Compare waveform output |

## Verification
The bench targets four groups of corner cases.

- **Lock interlock.** It checks the lock on both update paths. A design that gated only the command would load a new period on the next natural wrap.
- **Refused reset.** It issues the reset command while running and then reads the counter and control back. A design without the stopped-only rule would lose its configuration in mid-run.
- **Combined commands.** It writes several command bits at once, so a wrong priority order shows up as a changed period or a surviving control value.
- **DMA versus CPU clearing.** It makes CPU accesses and DMA reads to the acknowledging registers before the real DMA acknowledge. A decoder that ignored the source tag or the access kind would drop a request early.

The down-count reload and the compare waveform edges are checked at exact tick counts.

// File: rtl/tc_cmd_pkg.sv
`timescale 1ns/1ps
package tc_cmd_pkg;
   localparam logic [2:0] A_CTRL   = 3'd0;
   localparam logic [2:0] A_CMD    = 3'd1;
   localparam logic [2:0] A_FLAGS  = 3'd2;
   localparam logic [2:0] A_CNT    = 3'd3;
   localparam logic [2:0] A_PER    = 3'd4;
   localparam logic [2:0] A_PERBUF = 3'd5;
   localparam logic [2:0] A_CMP    = 3'd6;
   localparam logic [2:0] A_CMPBUF = 3'd7;

   localparam int CTRL_RUN  = 0;
   localparam int CTRL_LOCK = 1;
   localparam int CTRL_DOWN = 2;
   localparam int CTRL_W    = 3;

   typedef struct packed {
      logic reset;
      logic restart;
      logic update;
   } cmd_t;
endpackage

// File: rtl/tc_cmd_bufreg.sv
`timescale 1ns/1ps
module tc_cmd_bufreg #(
   parameter int           W    = 16,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         wr_act,
   input  logic         wr_buf,
   input  logic [W-1:0] wdata,
   input  logic         xfer,
   output logic [W-1:0] act,
   output logic [W-1:0] buf_q,
   output logic         valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act   <= INIT;
         buf_q <= INIT;
         valid <= 1'b0;
      end else if (clr) begin
         act   <= INIT;
         buf_q <= INIT;
         valid <= 1'b0;
      end else begin
         if (wr_act)
            act <= wdata;
         else if (xfer && valid)
            act <= buf_q;
         if (wr_buf) begin
            buf_q <= wdata;
            valid <= 1'b1;
         end else if (xfer) begin
            valid <= 1'b0;
         end
      end
   end

   AST_XFER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && valid && !wr_act && !clr) |=> (act == $past(buf_q))); // R4
   AST_BUF_MARKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_buf && !clr) |=> valid); // R4
endmodule

// File: rtl/tc_cmd_counter.sv
`timescale 1ns/1ps
module tc_cmd_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         restart,
   input  logic         tick,
   input  logic         down,
   input  logic [W-1:0] per,
   input  logic [W-1:0] cmp,
   input  logic         wr_cnt,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] cnt,
   output logic         wrap,
   output logic         cmp_hit,
   output logic         cmp_out
);
   logic live;
   logic at_end;

   assign live    = tick && !clr && !restart;
   assign at_end  = down ? (cnt == '0) : (cnt == per);
   assign wrap    = live && !wr_cnt && at_end;
   assign cmp_hit = live && (cnt == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         cmp_out <= 1'b0;
      end else if (clr || restart) begin
         cnt     <= '0;
         cmp_out <= 1'b0;
      end else begin
         if (wr_cnt)
            cnt <= wdata;
         else if (tick) begin
            if (at_end)
               cnt <= down ? per : '0;
            else
               cnt <= down ? cnt - 1'b1 : cnt + 1'b1;
         end
         if (tick)
            cmp_out <= (cnt < cmp);
      end
   end

   AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !down && cnt == per && !clr && !restart && !wr_cnt) |=> (cnt == '0)); // R1
   AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && down && cnt == '0 && !clr && !restart && !wr_cnt) |=> (cnt == $past(per))); // R2
   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0 && !cmp_out)); // R3
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr && !restart && !wr_cnt) |=> $stable(cnt)); // R11
endmodule

// File: rtl/tc_cmd_flags.sv
`timescale 1ns/1ps
module tc_cmd_flags (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       set_ovf,
   input  logic       set_cmp,
   input  logic       w1c,
   input  logic [1:0] w1c_bits,
   input  logic       ack_ovf,
   input  logic       ack_cmp,
   output logic       ovf_q,
   output logic       cmp_q
);
   logic kill_ovf;
   logic kill_cmp;

   assign kill_ovf = ack_ovf || (w1c && w1c_bits[0]);
   assign kill_cmp = ack_cmp || (w1c && w1c_bits[1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         cmp_q <= 1'b0;
      end else if (clr) begin
         ovf_q <= 1'b0;
         cmp_q <= 1'b0;
      end else begin
         if (set_ovf)       ovf_q <= 1'b1;
         else if (kill_ovf) ovf_q <= 1'b0;
         if (set_cmp)       cmp_q <= 1'b1;
         else if (kill_cmp) cmp_q <= 1'b0;
      end
   end

   AST_OVF_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_ovf && !set_ovf) |=> !ovf_q); // R8
   AST_CMP_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_cmp && !set_cmp) |=> !cmp_q); // R8
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ovf && !clr) |=> ovf_q); // R8
   AST_W1C_CMP: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c && w1c_bits[1] && !set_cmp) |=> !cmp_q); // R9
endmodule

// File: rtl/tc_cmd_timer.sv
`timescale 1ns/1ps
module tc_cmd_timer
   import tc_cmd_pkg::*;
#(
   parameter int           W        = 16,
   parameter int           AW       = 3,
   parameter logic [W-1:0] PER_INIT = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clk_en,
   input  logic [AW-1:0] bus_addr,
   input  logic [W-1:0]  bus_wdata,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic          bus_dma,
   output logic [W-1:0]  bus_rdata,
   output logic          ovf_req,
   output logic          cmp_req,
   output logic          cmp_out
);
   localparam int PAD_CTRL  = W - CTRL_W;
   localparam int PAD_FLAGS = W - 2;

   generate
      if (W < 4) begin : g_w_chk
         $error("tc_cmd_timer: W must be at least 4");
      end
      if (AW < 3) begin : g_aw_chk
         $error("tc_cmd_timer: AW must be at least 3");
      end
   endgenerate

   logic addr_ok;
   generate
      if (AW > 3) begin : g_addr_hi
         assign addr_ok = (bus_addr[AW-1:3] == '0);
      end else begin : g_addr_exact
         assign addr_ok = 1'b1;
      end
   endgenerate

   logic [2:0] sel;
   assign sel = bus_addr[2:0];

   logic wr_ctrl, wr_cmd, wr_flags, wr_cnt, wr_per, wr_perbuf, wr_cmp, wr_cmpbuf;
   assign wr_ctrl   = bus_wr && addr_ok && (sel == A_CTRL);
   assign wr_cmd    = bus_wr && addr_ok && (sel == A_CMD);
   assign wr_flags  = bus_wr && addr_ok && (sel == A_FLAGS);
   assign wr_cnt    = bus_wr && addr_ok && (sel == A_CNT);
   assign wr_per    = bus_wr && addr_ok && (sel == A_PER);
   assign wr_perbuf = bus_wr && addr_ok && (sel == A_PERBUF);
   assign wr_cmp    = bus_wr && addr_ok && (sel == A_CMP);
   assign wr_cmpbuf = bus_wr && addr_ok && (sel == A_CMPBUF);

   logic [CTRL_W-1:0] ctrl_q;
   logic run, lock, down;
   assign run  = ctrl_q[CTRL_RUN];
   assign lock = ctrl_q[CTRL_LOCK];
   assign down = ctrl_q[CTRL_DOWN];

   cmd_t cmd;
   assign cmd = wr_cmd ? cmd_t'(bus_wdata[2:0]) : cmd_t'(3'b000);

   logic do_reset, do_restart, do_update;
   assign do_reset   = cmd.reset && !run;
   assign do_restart = cmd.restart && !do_reset;
   assign do_update  = cmd.update && !do_reset && !do_restart && !lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (do_reset) begin
         ctrl_q <= '0;
      end else begin
         if (wr_ctrl)    ctrl_q <= bus_wdata[CTRL_W-1:0];
         if (do_restart) ctrl_q[CTRL_DOWN] <= 1'b0;
      end
   end

   logic tick, wrap, cmp_hit, xfer;
   logic [W-1:0] cnt, per_act, per_buf, cmp_act, cmp_buf;
   logic per_valid, cmp_valid;

   assign tick = clk_en && run;
   assign xfer = (wrap && !lock) || do_update;

   tc_cmd_bufreg #(.W(W), .INIT(PER_INIT)) u_per (
      .clk(clk), .rst_n(rst_n), .clr(do_reset),
      .wr_act(wr_per), .wr_buf(wr_perbuf), .wdata(bus_wdata), .xfer(xfer),
      .act(per_act), .buf_q(per_buf), .valid(per_valid)
   );

   tc_cmd_bufreg #(.W(W), .INIT('0)) u_cmp (
      .clk(clk), .rst_n(rst_n), .clr(do_reset),
      .wr_act(wr_cmp), .wr_buf(wr_cmpbuf), .wdata(bus_wdata), .xfer(xfer),
      .act(cmp_act), .buf_q(cmp_buf), .valid(cmp_valid)
   );

   tc_cmd_counter #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(do_reset), .restart(do_restart),
      .tick(tick), .down(down), .per(per_act), .cmp(cmp_act),
      .wr_cnt(wr_cnt), .wdata(bus_wdata),
      .cnt(cnt), .wrap(wrap), .cmp_hit(cmp_hit), .cmp_out(cmp_out)
   );

   logic ack_ovf, ack_cmp;
   assign ack_ovf = bus_dma && (wr_cnt || wr_per || wr_perbuf);
   assign ack_cmp = bus_dma && addr_ok && (bus_wr || bus_rd)
                    && ((sel == A_CMP) || (sel == A_CMPBUF));

   tc_cmd_flags u_flags (
      .clk(clk), .rst_n(rst_n), .clr(do_reset),
      .set_ovf(wrap), .set_cmp(cmp_hit),
      .w1c(wr_flags), .w1c_bits(bus_wdata[1:0]),
      .ack_ovf(ack_ovf), .ack_cmp(ack_cmp),
      .ovf_q(ovf_req), .cmp_q(cmp_req)
   );

   always_comb begin
      bus_rdata = '0;
      if (addr_ok) begin
         unique case (sel)
            A_CTRL:   bus_rdata = {{PAD_CTRL{1'b0}}, ctrl_q};
            A_CMD:    bus_rdata = '0;
            A_FLAGS:  bus_rdata = {{PAD_FLAGS{1'b0}}, cmp_req, ovf_req};
            A_CNT:    bus_rdata = cnt;
            A_PER:    bus_rdata = per_act;
            A_PERBUF: bus_rdata = per_buf;
            A_CMP:    bus_rdata = cmp_act;
            A_CMPBUF: bus_rdata = cmp_buf;
            default:  bus_rdata = '0;
         endcase
      end
   end

   AST_RESET_REFUSED_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.reset && run) |=> run); // R6
   AST_LOCK_HOLDS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !wr_per && !do_reset) |=> $stable(per_act)); // R5
   AST_RESTART_UP: assert property (@(posedge clk) disable iff (!rst_n)
      do_restart |=> !down); // R3
   AST_RESTART_BEATS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.restart && cmd.update && run && !wr_per) |=> $stable(per_act)); // R10
endmodule

// File: tb/tc_cmd_timer_tb.sv
`timescale 1ns/1ps
module tc_cmd_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_en = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_dma = 1'b0;
   logic [15:0] bus_rdata;
   logic        ovf_req, cmp_req, cmp_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tc_cmd_timer #(.W(16), .AW(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_dma(bus_dma), .bus_rdata(bus_rdata),
      .ovf_req(ovf_req), .cmp_req(cmp_req), .cmp_out(cmp_out)
   );

   localparam logic [1:0] K_WR = 2'd0, K_DWR = 2'd1, K_RD = 2'd2, K_DRD = 2'd3;
   localparam logic [2:0] CTRL = 3'd0, CMD = 3'd1, FLG = 3'd2, CNT = 3'd3,
                          PER = 3'd4, PERB = 3'd5, CMPR = 3'd6, CMPB = 3'd7;
   localparam int NV = 30;
   // fields: kind, address, data-or-expected, requirement number
   localparam logic [24:0] VEC [0:NV-1] = '{
      {K_RD, CNT,  16'h0000, 4'd6},  // R6 power-on counter
      {K_RD, PER,  16'hFFFF, 4'd6},  // R6 power-on period
      {K_RD, FLG,  16'h0000, 4'd6},  // R6 flags clear
      {K_RD, CTRL, 16'h0000, 4'd6},  // R6 control clear
      {K_WR, PERB, 16'h0010, 4'd4},  // R4 fill period buffer
      {K_RD, PER,  16'hFFFF, 4'd4},  // R4 not active yet
      {K_WR, CMPB, 16'h0005, 4'd4},
      {K_RD, CMPR, 16'h0000, 4'd4},
      {K_WR, CMD,  16'h0001, 4'd4},  // update command
      {K_RD, PER,  16'h0010, 4'd4},
      {K_RD, CMPR, 16'h0005, 4'd4},
      {K_WR, CTRL, 16'h0002, 4'd5},  // R5 lock on
      {K_WR, PERB, 16'h0020, 4'd5},
      {K_WR, CMD,  16'h0001, 4'd5},
      {K_RD, PER,  16'h0010, 4'd5},  // blocked
      {K_WR, CTRL, 16'h0000, 4'd5},
      {K_WR, CMD,  16'h0001, 4'd5},
      {K_RD, PER,  16'h0020, 4'd4},  // kept-valid buffer now moves
      {K_WR, CNT,  16'h0007, 4'd11},
      {K_WR, CTRL, 16'h0001, 4'd11}, // R11 run, but clk_en low
      {K_RD, CNT,  16'h0007, 4'd11},
      {K_WR, CMD,  16'h0004, 4'd6},  // reset while running
      {K_RD, CNT,  16'h0007, 4'd6},
      {K_RD, CTRL, 16'h0001, 4'd6},
      {K_WR, CTRL, 16'h0000, 4'd6},
      {K_WR, CMD,  16'h0004, 4'd6},  // reset while stopped
      {K_RD, CNT,  16'h0000, 4'd6},
      {K_RD, PER,  16'hFFFF, 4'd6},
      {K_RD, CTRL, 16'h0000, 4'd6},
      {K_RD, CMPR, 16'h0000, 4'd6}
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic op(input logic [1:0] kind, input logic [2:0] a,
                     input logic [15:0] d, input string tag);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = (kind == K_WR) || (kind == K_DWR);
      bus_rd    = (kind == K_RD) || (kind == K_DRD);
      bus_dma   = (kind == K_DWR) || (kind == K_DRD);
      #1;
      if (bus_rd) check(tag, bus_rdata, d);
      @(posedge clk);
      #1;
      bus_wr = 1'b0; bus_rd = 1'b0; bus_dma = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      clk_en = 1'b1;
      repeat (n) @(posedge clk);
      #1 clk_en = 1'b0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      check("R6 ovf_req after reset", {15'd0, ovf_req}, 16'd0);
      check("R6 cmp_out after reset", {15'd0, cmp_out}, 16'd0);

      for (int i = 0; i < NV; i++)
         op(VEC[i][24:23], VEC[i][22:20], VEC[i][19:4], $sformatf("R%0d vec %0d", VEC[i][3:0], i));

      // up count, compare waveform, wrap
      op(K_WR, PER, 16'd3, "");
      op(K_WR, CMPR, 16'd2, "");
      op(K_WR, CTRL, 16'h0001, "");
      ticks(1);
      op(K_RD, CNT, 16'd1, "R1 count up");
      check("R7 cmp_out high below compare", {15'd0, cmp_out}, 16'd1);
      ticks(2);
      op(K_RD, CNT, 16'd3, "R1 count up to period");
      check("R7 compare flag", {15'd0, cmp_req}, 16'd1);
      check("R7 cmp_out low at compare", {15'd0, cmp_out}, 16'd0);
      check("R1 no wrap yet", {15'd0, ovf_req}, 16'd0);
      ticks(1);
      op(K_RD, CNT, 16'd0, "R1 wrap to zero");
      check("R1 wrap flag", {15'd0, ovf_req}, 16'd1);

      // acknowledge by source
      op(K_WR, CNT, 16'd0, "");
      check("R8 cpu counter write keeps wrap flag", {15'd0, ovf_req}, 16'd1);
      op(K_DRD, CNT, 16'd0, "R8 dma read counter");
      check("R8 dma read keeps wrap flag", {15'd0, ovf_req}, 16'd1);
      op(K_DWR, PERB, 16'd3, "");
      check("R8 dma buffer write clears wrap flag", {15'd0, ovf_req}, 16'd0);
      op(K_WR, CMPR, 16'd2, "");
      check("R8 cpu compare write keeps compare flag", {15'd0, cmp_req}, 16'd1);
      op(K_DRD, CMPB, 16'd0, "R8 dma read compare buffer");
      check("R8 dma read clears compare flag", {15'd0, cmp_req}, 16'd0);

      // down count
      op(K_WR, CTRL, 16'h0005, "");
      ticks(1);
      op(K_RD, CNT, 16'd3, "R2 reload from period");
      check("R2 wrap flag on underflow", {15'd0, ovf_req}, 16'd1);
      ticks(2);
      op(K_RD, CNT, 16'd1, "R2 decrement");
      check("R7 compare flag counting down", {15'd0, cmp_req}, 16'd1);

      // write-one-to-clear
      op(K_WR, FLG, 16'h0001, "");
      check("R9 clear wrap flag", {15'd0, ovf_req}, 16'd0);
      check("R9 compare flag untouched", {15'd0, cmp_req}, 16'd1);
      op(K_WR, FLG, 16'h0002, "");
      check("R9 clear compare flag", {15'd0, cmp_req}, 16'd0);

      // restart
      ticks(2);
      op(K_RD, CNT, 16'd3, "R2 second underflow");
      check("R7 cmp_out high before restart", {15'd0, cmp_out}, 16'd1);
      op(K_WR, CMD, 16'h0002, "");
      op(K_RD, CNT, 16'd0, "R3 restart zeroes counter");
      check("R3 restart drives output low", {15'd0, cmp_out}, 16'd0);
      op(K_RD, CTRL, 16'h0001, "R3 restart clears down bit only");

      // command priority
      op(K_WR, CNT, 16'd5, "");
      op(K_WR, CMD, 16'h0007, "");
      op(K_RD, CNT, 16'd0, "R10 restart acts when reset refused");
      op(K_RD, CTRL, 16'h0001, "R10 refused reset keeps control");
      op(K_WR, PER, 16'd4, "");
      op(K_WR, PERB, 16'd9, "");
      op(K_WR, CNT, 16'd2, "");
      op(K_WR, CMD, 16'h0003, "");
      op(K_RD, CNT, 16'd0, "R10 restart with update");
      op(K_RD, PER, 16'd4, "R10 restart beats update");

      // lock against natural wrap
      op(K_WR, CTRL, 16'h0003, "");
      op(K_WR, CNT, 16'd4, "");
      ticks(1);
      op(K_RD, CNT, 16'd0, "R1 wrap under lock");
      op(K_RD, PER, 16'd4, "R5 lock blocks wrap transfer");
      op(K_WR, CTRL, 16'h0001, "");
      op(K_WR, CNT, 16'd4, "");
      ticks(1);
      op(K_RD, PER, 16'd9, "R4 wrap transfers buffer");

      // reset while stopped, flags set
      check("R1 wrap flag before reset", {15'd0, ovf_req}, 16'd1);
      op(K_WR, CTRL, 16'h0000, "");
      op(K_WR, PERB, 16'd7, "");
      op(K_WR, CMD, 16'h0007, "");
      op(K_RD, PER, 16'hFFFF, "R10 reset beats restart and update");
      check("R6 reset clears wrap flag", {15'd0, ovf_req}, 16'd0);
      op(K_RD, PERB, 16'hFFFF, "R6 reset restores buffer");

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end
endmodule